// File: doc/BRIEF.md
# Dual-Mode I/O Address Translator

This block receives single transfers from the processor side and turns those that land in an 8 MB I/O window based at 0x8000_0000 into cycles on a 64 KB I/O master port. A live mode level decides how a window offset becomes an I/O address. With the level low, the offset is cut down to its 16 low bits. With the level high, a sparse layout is packed into a dense one: the five lowest offset bits are kept, and offset bits 22:12 move down to bits 15:5. The level is sampled when a request is accepted, so changing it later has no effect on a transfer already under way.

Transfers are 1, 2 or 4 bytes and little-endian, and they may be unaligned. Each downstream beat is one aligned 32-bit word with byte enables. An access that crosses a word boundary is issued as two beats to consecutive word addresses, and the 16-bit address wraps. A byte read at 0xBFFF_FFF0 is an interrupt acknowledge. It takes the vector from the interrupt-controller port in the accept cycle and creates no downstream cycle. Every other request is answered with an error and no downstream cycle: a wrong size, a multi-byte or write access to the acknowledge location, or an address outside the window.

Top module: `io_xlate_bridge`

## Requirements
- R1: Only requests with address in [0x8000_0000, 0x8080_0000) create downstream cycles; any other address except a valid acknowledge gets `resp_err`=1 and no downstream cycle.
- R2: With `mode_sparse`=0 at acceptance, the dense I/O byte address is the window offset ANDed with 0xFFFF.
- R3: With `mode_sparse`=1 at acceptance, the dense I/O byte address is offset[4:0] ORed with (offset & 0x7FF_F000) shifted right by 7.
- R4: The mode used is the value at the accept edge; a change afterwards does not alter that transfer.
- R5: `req_size` holds the byte count (1, 2 or 4). Byte k of `req_wdata` (bits 8k+7:8k) goes to dense address D+k. Each beat carries `io_addr` = word address (low two bits 0), and `io_be` bit j marks byte lane j = address io_addr+j, with data in `io_wdata` bits 8j+7:8j.
- R6: A transfer whose bytes span two words uses two beats, the second at the first word address + 4 (mod 64 KB), holding the remaining lanes.
- R7: A read returns byte D+k in `resp_rdata` bits 8k+7:8k for k below the size, with zeros above.
- R8: A read of size 1 at 0xBFFF_FFF0 pulses `ack_take` in the accept cycle, returns `ack_vector` zero-extended with `resp_err`=0, and makes no downstream cycle.
- R9: A size other than 1, 2 or 4, or a write or multi-byte access to 0xBFFF_FFF0, gets `resp_err`=1 with no downstream cycle and no `ack_take`.
- R10: `req_ready` is high only when idle. Beat outputs hold steady while `io_ready` is low. `resp_valid` pulses for one cycle, exactly one cycle after the last beat handshake, or one cycle after acceptance for a request with no beats.
- R11: After reset, `req_ready`=1 while `io_valid` and `resp_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sparse | input | 1 | Address mode level: 0 truncate, 1 pack |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when high with req_valid |
| req_addr | input | 32 | Processor byte address |
| req_write | input | 1 | 1 write, 0 read |
| req_size | input | 3 | Byte count |
| req_wdata | input | 32 | Write data, little-endian |
| resp_valid | output | 1 | Response pulse |
| resp_err | output | 1 | Error response |
| resp_rdata | output | 32 | Read data |
| io_valid | output | 1 | Downstream beat valid |
| io_ready | input | 1 | Downstream beat accepted |
| io_write | output | 1 | Beat direction |
| io_addr | output | 16 | Word-aligned I/O address |
| io_be | output | 4 | Byte-lane enables |
| io_wdata | output | 32 | Beat write data |
| io_rdata | input | 32 | Beat read data, taken at handshake |
| ack_take | output | 1 | Acknowledge strobe to interrupt controller |
| ack_vector | input | 8 | Pending interrupt vector |

## Verification
The first beat of an I/O request appears in the cycle after the accept edge. A second beat follows the cycle after the first handshake, and the response arrives exactly one cycle after the last handshake. Error and acknowledge responses come one cycle after acceptance, and `ack_take` is visible before the accept edge. The bench drives inputs on falling edges and predicts each beat and response in a reference model. At every falling edge it compares the beat that the next rising edge will complete, and whether a response is due in the present cycle. Stall patterns on `io_ready` stretch the beats so that the timing rule is exercised under back-pressure.

// File: rtl/io_xlate_pkg.sv
package io_xlate_pkg;
    localparam int IO_AW  = 16;
    localparam int BEAT_B = 4;
    localparam int DW     = 8 * BEAT_B;
    localparam int LANE_W = 2 * BEAT_B - 1;
    localparam int SPAN_W = 8 * LANE_W;

    typedef enum logic [1:0] {ST_IDLE, ST_BEAT0, ST_BEAT1, ST_RESP} xl_state_e;

    typedef struct packed {
        xl_state_e          st;
        logic               wr;
        logic [IO_AW-1:0]   waddr;
        logic [LANE_W-1:0]  lanes;
        logic [SPAN_W-1:0]  wbuf;
        logic [DW-1:0]      rlo;
        logic [1:0]         shift;
        logic [2:0]         size;
        logic               err;
        logic [DW-1:0]      rdata;
    } xl_regs_t;

    function automatic logic [BEAT_B-1:0] size_mask(input logic [2:0] sz);
        case (sz)
            3'd1:    size_mask = 4'b0001;
            3'd2:    size_mask = 4'b0011;
            3'd4:    size_mask = 4'b1111;
            default: size_mask = 4'b0000;
        endcase
    endfunction

    function automatic logic [DW-1:0] assemble(input logic [SPAN_W-1:0] raw,
                                                input logic [1:0] sh,
                                                input logic [2:0] sz);
        logic [SPAN_W-1:0] t;
        logic [BEAT_B-1:0] m;
        t = raw >> {sh, 3'b000};
        m = size_mask(sz);
        for (int i = 0; i < BEAT_B; i++)
            assemble[8*i +: 8] = m[i] ? t[8*i +: 8] : 8'h00;
    endfunction
endpackage

// File: rtl/io_addr_pack.sv
module io_addr_pack #(
    parameter int WIN_BITS   = 23,
    parameter int IO_AW      = 16,
    parameter int LO_BITS    = 5,
    parameter int PAGE_SHIFT = 12
) (
    input  logic [WIN_BITS-1:0] off,
    input  logic                sparse,
    output logic [IO_AW-1:0]    dense
);
    localparam int HI_BITS = IO_AW - LO_BITS;

    logic [IO_AW-1:0] packed_addr;
    logic [IO_AW-1:0] trunc_addr;

    assign packed_addr = {off[PAGE_SHIFT +: HI_BITS], off[LO_BITS-1:0]};
    assign trunc_addr  = off[IO_AW-1:0];
    assign dense       = sparse ? packed_addr : trunc_addr;
endmodule

// File: rtl/io_lane_split.sv
module io_lane_split
    import io_xlate_pkg::*;
(
    input  logic [1:0]        lane,
    input  logic [2:0]        size,
    input  logic [DW-1:0]     wdata,
    output logic [LANE_W-1:0] lanes,
    output logic [SPAN_W-1:0] wspread
);
    logic [BEAT_B-1:0] m;
    logic [DW-1:0]     wmask;

    always_comb begin
        m = size_mask(size);
        for (int i = 0; i < BEAT_B; i++)
            wmask[8*i +: 8] = m[i] ? wdata[8*i +: 8] : 8'h00;
        lanes   = {{(LANE_W-BEAT_B){1'b0}}, m} << lane;
        wspread = {{(SPAN_W-DW){1'b0}}, wmask} << {lane, 3'b000};
    end
endmodule

// File: rtl/io_xlate_bridge.sv
module io_xlate_bridge
    import io_xlate_pkg::*;
#(
    parameter logic [31:0] WIN_BASE = 32'h8000_0000,
    parameter int          WIN_BITS = 23,
    parameter logic [31:0] ACK_ADDR = 32'hBFFF_FFF0,
    parameter int          VEC_W    = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_sparse,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [31:0]      req_addr,
    input  logic             req_write,
    input  logic [2:0]       req_size,
    input  logic [31:0]      req_wdata,
    output logic             resp_valid,
    output logic             resp_err,
    output logic [31:0]      resp_rdata,
    output logic             io_valid,
    input  logic             io_ready,
    output logic             io_write,
    output logic [15:0]      io_addr,
    output logic [3:0]       io_be,
    output logic [31:0]      io_wdata,
    input  logic [31:0]      io_rdata,
    output logic             ack_take,
    input  logic [VEC_W-1:0] ack_vector
);
    localparam int HI_W = LANE_W - BEAT_B;

    xl_regs_t q, d;

    logic [IO_AW-1:0]  dense;
    logic [LANE_W-1:0] lanes;
    logic [SPAN_W-1:0] wspread;
    logic in_win, is_ack, size_ok, ack_ok, go_io;

    io_addr_pack #(.WIN_BITS(WIN_BITS), .IO_AW(IO_AW)) u_pack (
        .off    (req_addr[WIN_BITS-1:0]),
        .sparse (mode_sparse),
        .dense  (dense)
    );

    io_lane_split u_split (
        .lane    (dense[1:0]),
        .size    (req_size),
        .wdata   (req_wdata),
        .lanes   (lanes),
        .wspread (wspread)
    );

    assign in_win  = (req_addr[31:WIN_BITS] == WIN_BASE[31:WIN_BITS]);
    assign is_ack  = (req_addr == ACK_ADDR);
    assign size_ok = (size_mask(req_size) != '0);
    assign ack_ok  = is_ack && !req_write && (req_size == 3'd1);
    assign go_io   = in_win && size_ok;

    always_comb begin
        d        = q;
        ack_take = 1'b0;
        case (q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    if (go_io) begin
                        d.st    = ST_BEAT0;
                        d.wr    = req_write;
                        d.waddr = {dense[IO_AW-1:2], 2'b00};
                        d.lanes = lanes;
                        d.wbuf  = wspread;
                        d.shift = dense[1:0];
                        d.size  = req_size;
                        d.err   = 1'b0;
                        d.rdata = '0;
                    end else begin
                        d.st     = ST_RESP;
                        d.err    = !ack_ok;
                        d.rdata  = ack_ok ? {{(DW-VEC_W){1'b0}}, ack_vector} : '0;
                        ack_take = ack_ok;
                    end
                end
            end
            ST_BEAT0: begin
                if (io_ready) begin
                    d.rlo = io_rdata;
                    if (|q.lanes[LANE_W-1:BEAT_B]) begin
                        d.st    = ST_BEAT1;
                        d.waddr = q.waddr + IO_AW'(BEAT_B);
                    end else begin
                        d.st    = ST_RESP;
                        d.rdata = q.wr ? '0
                                : assemble({{(SPAN_W-DW){1'b0}}, io_rdata}, q.shift, q.size);
                    end
                end
            end
            ST_BEAT1: begin
                if (io_ready) begin
                    d.st    = ST_RESP;
                    d.rdata = q.wr ? '0
                            : assemble({io_rdata[8*HI_W-1:0], q.rlo}, q.shift, q.size);
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign req_ready  = (q.st == ST_IDLE);
    assign io_valid   = (q.st == ST_BEAT0) || (q.st == ST_BEAT1);
    assign io_write   = q.wr;
    assign io_addr    = q.waddr;
    assign io_be      = (q.st == ST_BEAT1) ? {1'b0, q.lanes[LANE_W-1:BEAT_B]}
                                           : q.lanes[BEAT_B-1:0];
    assign io_wdata   = (q.st == ST_BEAT1) ? {8'h00, q.wbuf[SPAN_W-1:DW]}
                                           : q.wbuf[DW-1:0];
    assign resp_valid = (q.st == ST_RESP);
    assign resp_err   = q.err;
    assign resp_rdata = q.rdata;
endmodule

// File: rtl/io_xlate_checker.sv
module io_xlate_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        req_ready,
    input logic        io_valid,
    input logic        io_ready,
    input logic        io_write,
    input logic [15:0] io_addr,
    input logic [3:0]  io_be,
    input logic [31:0] io_wdata,
    input logic        resp_valid,
    input logic        resp_err,
    input logic        ack_take
);
    a_r10_beat_hold: assert property (@(posedge clk) disable iff (!rst_n)
        io_valid && !io_ready |=> io_valid && $stable(io_addr) && $stable(io_be)
                                   && $stable(io_wdata) && $stable(io_write));

    a_r10_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (io_valid || resp_valid) |-> !req_ready);

    a_r10_resp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> !resp_valid);

    a_r5_word_beat: assert property (@(posedge clk) disable iff (!rst_n)
        io_valid |-> (io_addr[1:0] == 2'b00) && (io_be != 4'b0000));

    a_r8_ack_resp: assert property (@(posedge clk) disable iff (!rst_n)
        ack_take |=> resp_valid && !resp_err && !io_valid);
endmodule

bind io_xlate_bridge io_xlate_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_ready  (req_ready),
    .io_valid   (io_valid),
    .io_ready   (io_ready),
    .io_write   (io_write),
    .io_addr    (io_addr),
    .io_be      (io_be),
    .io_wdata   (io_wdata),
    .resp_valid (resp_valid),
    .resp_err   (resp_err),
    .ack_take   (ack_take)
);

// File: tb/sim_io_xlate_bridge.sv
module sim_io_xlate_bridge;
    logic clk = 0, rst_n = 0, mode_sparse = 0;
    logic req_valid = 0, req_write = 0;
    logic [31:0] req_addr = 0, req_wdata = 0;
    logic [2:0]  req_size = 0;
    logic req_ready, resp_valid, resp_err, io_valid, io_write, ack_take;
    logic [31:0] resp_rdata, io_wdata;
    logic [15:0] io_addr;
    logic [3:0]  io_be;
    logic        io_ready = 0;
    logic [31:0] io_rdata = 0;
    logic [7:0]  ack_vector = 8'hA7;

    int errors = 0, checks = 0, cyc = 0;
    bit stall_mode = 0, resp_due = 0;
    logic [7:0] mem [int];
    logic [52:0] expq [$];

    always #5 clk = ~clk;

    io_xlate_bridge u0 (.*);

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] rd_byte(input int a);
        int k = a & 32'hFFFF;
        return mem.exists(k) ? mem[k] : (k[7:0] ^ k[15:8] ^ 8'h5A);
    endfunction

    // downstream device + beat monitor, one step per falling edge
    always @(negedge clk) begin
        logic [52:0] e;
        cyc++;
        if (rst_n) begin
            if (resp_valid !== resp_due || resp_due) chk(resp_valid === resp_due, "R10 resp timing", {31'b0, resp_valid}, {31'b0, resp_due});
            resp_due = 0;
            if (io_valid && req_ready) chk(0, "R10 ready while busy", 1, 0);
        end
        io_ready = stall_mode ? (cyc % 4 == 3) : (cyc % 3 != 1);
        io_rdata = {rd_byte(io_addr + 3), rd_byte(io_addr + 2), rd_byte(io_addr + 1), rd_byte(io_addr)};
        if (rst_n && io_valid && io_ready) begin
            if (expq.size() == 0) chk(0, "R1/R9 unexpected downstream beat", {16'b0, io_addr}, 0);
            else begin
                e = expq.pop_front();
                chk(io_addr === e[51:36] && io_be === e[35:32] && io_write === e[52],
                    "R2/R3/R5/R6 beat addr/be", {11'b0, io_write, io_addr, io_be}, {11'b0, e[52:32]});
                if (e[52]) begin
                    for (int j = 0; j < 4; j++)
                        if (io_be[j]) begin
                            chk(io_wdata[8*j +: 8] === e[8*j +: 8], "R5 write lane data", {24'b0, io_wdata[8*j +: 8]}, {24'b0, e[8*j +: 8]});
                            mem[(io_addr + j) & 32'hFFFF] = io_wdata[8*j +: 8];
                        end
                end
                if (expq.size() == 0) resp_due = 1;
            end
        end
    end

    task automatic access(input logic [31:0] addr, input int size, input bit wr, input logic [31:0] wd,
                          input bit flip, input string tag);
        int off, dn, ba, word, cur;
        bit io, ackok, experr, seen_ack;
        logic [31:0] exprd;
        logic [52:0] b;
        io    = (addr >= 32'h8000_0000) && (addr < 32'h8080_0000) && (size == 1 || size == 2 || size == 4);
        ackok = (addr == 32'hBFFF_FFF0) && !wr && size == 1;
        experr = !io && !ackok;
        off = addr - 32'h8000_0000;
        dn  = mode_sparse ? (((off & 32'h1F) | ((off & 32'h7FFF000) >> 7)) & 32'hFFFF) : (off & 32'hFFFF);
        exprd = ackok ? {24'b0, ack_vector} : 0;
        if (io) begin
            cur = -1; b = 0;
            for (int i = 0; i < size; i++) begin
                ba = (dn + i) & 32'hFFFF; word = ba & 32'hFFFC;
                if (word != cur) begin
                    if (cur >= 0) expq.push_back(b);
                    cur = word; b = 0; b[52] = wr; b[51:36] = word[15:0];
                end
                b[32 + (ba & 3)] = 1'b1;
                b[8*(ba & 3) +: 8] = wd[8*i +: 8];
                if (!wr) exprd[8*i +: 8] = rd_byte(ba);
            end
            expq.push_back(b);
        end
        req_addr = addr; req_size = size[2:0]; req_write = wr; req_wdata = wd; req_valid = 1;
        #1;
        chk(req_ready === 1, {tag, " R10 ready when idle"}, {31'b0, req_ready}, 1);
        seen_ack = ack_take;
        chk(seen_ack === ackok, {tag, " R8/R9 ack_take"}, {31'b0, seen_ack}, {31'b0, ackok});
        @(posedge clk);
        if (!io) resp_due = 1;
        @(negedge clk);
        req_valid = 0;
        if (flip) mode_sparse = ~mode_sparse;
        for (int w = 0; w < 60 && !resp_valid; w++) @(negedge clk);
        chk(resp_valid === 1, {tag, " R10 response arrives"}, {31'b0, resp_valid}, 1);
        chk(resp_err === experr, {tag, " R1/R9 error flag"}, {31'b0, resp_err}, {31'b0, experr});
        if (!wr && !experr) chk(resp_rdata === exprd, {tag, " R7/R8 read data"}, resp_rdata, exprd);
        chk(expq.size() == 0, {tag, " R6 all beats issued"}, expq.size(), 0);
        expq.delete();
        @(negedge clk);
    endtask

    always @(posedge clk) if (cyc > 150000) begin
        errors++; checks++;
        $display("FAIL watchdog actual=%0d expected<150000", cyc);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(req_ready === 1 && io_valid === 0 && resp_valid === 0, "R11 reset state",
            {29'b0, req_ready, io_valid, resp_valid}, 32'h4);
        rst_n = 1;
        @(negedge clk);
        mode_sparse = 0;
        access(32'h8000_1234, 4, 1, 32'hDEADBEEF, 0, "R2 aligned write");
        access(32'h8000_1234, 4, 0, 0, 0, "R7 aligned read");
        access(32'h8012_3456, 2, 1, 32'h0000_CAFE, 0, "R2 truncation");
        access(32'h8000_3456, 2, 0, 0, 0, "R2 alias read");
        mode_sparse = 1;
        access(32'h8012_3457, 1, 1, 32'h0000_0077, 0, "R3 sparse write");
        access(32'h8012_3457, 1, 0, 0, 0, "R3 sparse read");
        access(32'h807F_F01F, 4, 0, 0, 0, "R3 top of window");
        mode_sparse = 0;
        access(32'h8000_2003, 2, 1, 32'h0000_A55A, 0, "R6 crossing write");
        access(32'h8000_2001, 4, 0, 0, 0, "R6 crossing read");
        access(32'h8000_FFFE, 4, 1, 32'h1122_3344, 0, "R6 wrap write");
        access(32'h8000_FFFD, 4, 0, 0, 0, "R6 wrap read");
        stall_mode = 1;
        mode_sparse = 1;
        access(32'h8045_6789, 4, 0, 0, 1, "R4 mode flip after accept");
        access(32'h8045_6789, 2, 1, 32'h0000_BEEF, 1, "R4 mode flip write");
        stall_mode = 0;
        access(32'h8000_0010, 3, 1, 32'h1, 0, "R9 size 3");
        access(32'h8000_0010, 0, 0, 0, 0, "R9 size 0");
        access(32'hBFFF_FFF0, 1, 0, 0, 0, "R8 ack read");
        ack_vector = 8'h3C;
        access(32'hBFFF_FFF0, 1, 0, 0, 0, "R8 ack second vector");
        access(32'hBFFF_FFF0, 2, 0, 0, 0, "R9 ack size 2");
        access(32'hBFFF_FFF0, 1, 1, 32'h5, 0, "R9 ack write");
        access(32'h8080_0000, 4, 0, 0, 0, "R1 above window");
        access(32'h7FFF_FFFC, 4, 1, 32'h9, 0, "R1 below window");
        for (int n = 0; n < 60; n++) begin
            int sz;
            sz = (n % 3 == 0) ? 1 : ((n % 3 == 1) ? 2 : 4);
            mode_sparse = $urandom_range(0, 1);
            stall_mode  = $urandom_range(0, 1);
            access(32'h8000_0000 | ($urandom & 32'h007F_FFFF), sz, n % 2 == 0, $urandom, n % 5 == 0, "R5/R7 mixed");
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule